// File: doc/BRIEF.md
# Buffered PWM Reload Controller

This block is the timebase of one PWM channel group. Its compare values and its clock divider are double-buffered. Software writes new values into a set of shadow registers through a simple register port. It then raises a load-ready flag. The shadow values move into the active registers only at a reload point that the control bits select. A reload point can be the tick on which the counter reaches the mid compare, the tick on which it wraps at the end compare, or both. With the immediate-load bit set, the move happens on the first prescaled tick instead. The active values drive a prescaled up-counter. A one-cycle strobe marks each transfer.

Load-ready is held by a two-state controller. `LD_IDLE` means no load is pending. The **arm** transition (a write of 1 to bit 0 of the load register) moves it to `LD_ARMED`. While armed, the shadow compare values and the shadow divider are write-protected. The **commit** transition (a transfer into the active registers) returns it to `LD_IDLE`.

The block also samples an external input twice per PWM cycle. The first sample is taken when the fixed dead interval after the cycle start ends. The second is taken when the fixed dead interval after the mid compare ends. Both samples can be read back.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset the counter is 0, the strobe is low and load-ready is 0. Both captures are 0 and the divider is 0. The active and shadow mid compare hold MID_RST, and the active and shadow end compare hold END_RST.
- R2: The counter changes only on a prescaled tick. On a tick it increments, unless its value is greater than or equal to the active end compare, in which case it becomes 0.
- R3: A prescaled tick occurs once every 2^d clocks, where d is the active 3-bit divider (0 gives every clock, 7 gives every 128 clocks).
- R4: With mid_en set and load-ready 1, a transfer happens on the tick where the counter equals the active mid compare.
- R5: With end_en set and load-ready 1, a transfer happens on the tick where the counter wraps to 0. The new divider therefore applies from the start of the next cycle.
- R6: With mid_en, end_en and imm_load all 0, no transfer ever happens and load-ready stays 1.
- R7: With imm_load set and load-ready 1, a transfer happens on the next prescaled tick, whatever the counter value.
- R8: A transfer copies all three shadow values to the active registers. At that same clock edge, reload_stb goes high for exactly one cycle and load-ready returns to 0.
- R9: Reads return shadow values. The register map is as follows.
  - Address 0 is control: bit 0 is mid_en, bit 1 is end_en, bit 2 is imm_load, and bits 6:4 are the shadow divider.
  - Address 1 is the shadow mid compare.
  - Address 2 is the shadow end compare.
  - Address 3 is load/status: bit 0 is load-ready, bits 2:1 are the captures.
- R10: While load-ready is 1, writes to addresses 1 and 2 and to the divider field are ignored. Control bits 2:0 are still written.
- R11: Capture bit 0 takes cap_in on the tick where the counter equals DEAD_TICKS. Capture bit 1 takes cap_in on the tick where the counter equals the active mid compare plus DEAD_TICKS.
- R12: Writing address 3 with bit 0 set sets load-ready. Writing it with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | W | Read data (combinational) |
| cap_in | input | 1 | External input sampled at dead-interval ends |
| cnt | output | W | PWM counter |
| reload_stb | output | 1 | One-cycle pulse on transfer |
| act_mid | output | W | Active mid compare |
| act_end | output | W | Active end compare |
| act_div | output | 3 | Active divider exponent |
| dt_cap | output | 2 | Captured samples |

## Verification
The embedded assertions check several properties on every cycle:
- the counter steps by one or holds depending on the tick, and the prescaler restarts after each tick;
- the strobe lasts one cycle and coincides with the return to `LD_IDLE`;
- active values never change without a transfer;
- protected shadow writes leave the shadow registers untouched;
- an armed load with no reload source stays armed.

Only the bench scenarios can show the following:
- that transfers land on the right reload point for each enable combination;
- that a new divider takes effect at the wrap;
- that captured samples and read-back values are correct;
- that a locked write was discarded rather than deferred.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
    localparam int DIV_W = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MID  = 2'd1;
    localparam logic [1:0] ADDR_END  = 2'd2;
    localparam logic [1:0] ADDR_LOAD = 2'd3;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;
endpackage

// File: rtl/pwm_load_fsm.sv
module pwm_load_fsm
    import pwm_reload_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic       wr_bit0,
    input  logic       tick,
    input  logic       mid_hit,
    input  logic       end_hit,
    input  logic       mid_en,
    input  logic       end_en,
    input  logic       imm_load,
    output logic       ld_ready,
    output logic       transfer,
    output logic       reload_stb
);
    ld_state_e state_q, state_d;
    logic      arm;

    assign arm = wr_en && (wr_addr == ADDR_LOAD) && wr_bit0;

    // state register and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LD_IDLE;
            reload_stb <= 1'b0;
        end else begin
            state_q    <= state_d;
            reload_stb <= transfer;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        transfer = 1'b0;
        ld_ready = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (arm) state_d = LD_ARMED;
            end
            LD_ARMED: begin
                ld_ready = 1'b1;
                transfer = tick && (imm_load || (mid_en && mid_hit) || (end_en && end_hit));
                if (transfer) state_d = LD_IDLE;
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // R8
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |=> !reload_stb);
    // R8
    stb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |-> (state_q == LD_IDLE));
    // R6
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_ARMED && !imm_load && !mid_en && !end_en) |=> (state_q == LD_ARMED));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_reload_pkg::*;
#(
    parameter int W          = 16,
    parameter int DEAD_TICKS = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] act_div,
    input  logic [W-1:0]     act_mid,
    input  logic [W-1:0]     act_end,
    input  logic             cap_in,
    output logic             tick,
    output logic             mid_hit,
    output logic             end_hit,
    output logic [W-1:0]     cnt,
    output logic [1:0]       dt_cap
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [W-1:0]     cnt_q;
    logic [W:0]       dt1_point;
    logic             dt0_end, dt1_end;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(act_div));
        end
    end

    assign tick      = (pre_q == mask);
    assign mid_hit   = tick && (cnt_q == act_mid);
    assign end_hit   = tick && (cnt_q >= act_end);
    assign dt1_point = {1'b0, act_mid} + (W+1)'(DEAD_TICKS);
    assign dt0_end   = tick && (cnt_q == W'(DEAD_TICKS));
    assign dt1_end   = tick && ({1'b0, cnt_q} == dt1_point);
    assign cnt       = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            cnt_q  <= '0;
            dt_cap <= 2'b00;
        end else begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (end_hit)   cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + W'(1);
            if (dt0_end) dt_cap[0] <= cap_in;
            if (dt1_end) dt_cap[1] <= cap_in;
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q < act_end) |=> (cnt_q == $past(cnt_q) + W'(1)));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R3
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_reload_pkg::*;
#(
    parameter int W       = 16,
    parameter int MID_RST = 4,
    parameter int END_RST = 9
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [1:0]       rd_addr,
    output logic [W-1:0]     rd_data,
    input  logic             ld_ready,
    input  logic             transfer,
    input  logic [1:0]       dt_cap,
    output logic             mid_en,
    output logic             end_en,
    output logic             imm_load,
    output logic [W-1:0]     act_mid,
    output logic [W-1:0]     act_end,
    output logic [DIV_W-1:0] act_div
);
    logic [W-1:0]     buf_mid, buf_end;
    logic [DIV_W-1:0] buf_div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_en   <= 1'b0;
            end_en   <= 1'b0;
            imm_load <= 1'b0;
            buf_div  <= '0;
            buf_mid  <= W'(MID_RST);
            buf_end  <= W'(END_RST);
            act_div  <= '0;
            act_mid  <= W'(MID_RST);
            act_end  <= W'(END_RST);
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    ADDR_CTRL: begin
                        mid_en   <= wr_data[0];
                        end_en   <= wr_data[1];
                        imm_load <= wr_data[2];
                        if (!ld_ready) buf_div <= wr_data[4 +: DIV_W];
                    end
                    ADDR_MID: if (!ld_ready) buf_mid <= wr_data;
                    ADDR_END: if (!ld_ready) buf_end <= wr_data;
                    default: ;
                endcase
            end
            if (transfer) begin
                act_div <= buf_div;
                act_mid <= buf_mid;
                act_end <= buf_end;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[0]           = mid_en;
                rd_data[1]           = end_en;
                rd_data[2]           = imm_load;
                rd_data[4 +: DIV_W]  = buf_div;
            end
            ADDR_MID:  rd_data = buf_mid;
            ADDR_END:  rd_data = buf_end;
            default: begin
                rd_data[0]   = ld_ready;
                rd_data[2:1] = dt_cap;
            end
        endcase
    end

    // R10
    lock_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ready && wr_en && wr_addr == ADDR_MID) |=> $stable(buf_mid));
    // R10
    lock_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ready && wr_en && wr_addr == ADDR_END) |=> $stable(buf_end));
    // R8
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !transfer |=> ($stable(act_mid) && $stable(act_end) && $stable(act_div)));
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int W          = 16,
    parameter int MID_RST    = 4,
    parameter int END_RST    = 9,
    parameter int DEAD_TICKS = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [1:0]       rd_addr,
    output logic [W-1:0]     rd_data,
    input  logic             cap_in,
    output logic [W-1:0]     cnt,
    output logic             reload_stb,
    output logic [W-1:0]     act_mid,
    output logic [W-1:0]     act_end,
    output logic [DIV_W-1:0] act_div,
    output logic [1:0]       dt_cap
);
    logic tick, mid_hit, end_hit;
    logic mid_en, end_en, imm_load;
    logic ld_ready, transfer;

    pwm_regfile #(.W(W), .MID_RST(MID_RST), .END_RST(END_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ld_ready(ld_ready), .transfer(transfer), .dt_cap(dt_cap),
        .mid_en(mid_en), .end_en(end_en), .imm_load(imm_load),
        .act_mid(act_mid), .act_end(act_end), .act_div(act_div)
    );

    pwm_timebase #(.W(W), .DEAD_TICKS(DEAD_TICKS)) u_tb (
        .clk(clk), .rst_n(rst_n),
        .act_div(act_div), .act_mid(act_mid), .act_end(act_end),
        .cap_in(cap_in),
        .tick(tick), .mid_hit(mid_hit), .end_hit(end_hit),
        .cnt(cnt), .dt_cap(dt_cap)
    );

    pwm_load_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0]),
        .tick(tick), .mid_hit(mid_hit), .end_hit(end_hit),
        .mid_en(mid_en), .end_en(end_en), .imm_load(imm_load),
        .ld_ready(ld_ready), .transfer(transfer), .reload_stb(reload_stb)
    );
endmodule

// File: tb/pwm_reload_ctrl_bench.sv
module pwm_reload_ctrl_bench;
    localparam int W    = 16;
    localparam int DEAD = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic         cap_in = 1'b0;
    logic [W-1:0] rd_data, cnt, act_mid, act_end;
    logic         reload_stb;
    logic [2:0]   act_div;
    logic [1:0]   dt_cap;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pwm_reload_ctrl #(.W(W), .MID_RST(4), .END_RST(9), .DEAD_TICKS(DEAD)) u_pwm_reload_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .cnt(cnt),
        .reload_stb(reload_stb), .act_mid(act_mid), .act_end(act_end),
        .act_div(act_div), .dt_cap(dt_cap)
    );

    // behavioural reference model
    int m_pre, m_cnt, m_bmid, m_bend, m_bdiv, m_amid, m_aend, m_adiv;
    bit m_mid_en, m_end_en, m_imm, m_ldok, m_stb;
    bit [1:0] m_dt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_bmid = 4; m_bend = 9; m_bdiv = 0;
            m_amid = 4; m_aend = 9; m_adiv = 0;
            m_mid_en = 0; m_end_en = 0; m_imm = 0; m_ldok = 0; m_stb = 0; m_dt = 0;
        end else begin
            bit tk, xfer, wrap, old_ldok;
            int old_cnt;
            tk = (m_pre == (1 << m_adiv) - 1);
            wrap = tk && (m_cnt >= m_aend);
            xfer = m_ldok && tk && (m_imm || (m_mid_en && m_cnt == m_amid) || (m_end_en && wrap));
            old_ldok = m_ldok;
            old_cnt = m_cnt;
            if (tk && old_cnt == DEAD) m_dt[0] = cap_in;
            if (tk && old_cnt == m_amid + DEAD) m_dt[1] = cap_in;
            m_pre = tk ? 0 : m_pre + 1;
            if (wrap) m_cnt = 0; else if (tk) m_cnt = (m_cnt + 1) % 65536;
            if (xfer) begin m_amid = m_bmid; m_aend = m_bend; m_adiv = m_bdiv; end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_mid_en = wr_data[0]; m_end_en = wr_data[1]; m_imm = wr_data[2];
                        if (!old_ldok) m_bdiv = int'(wr_data[6:4]);
                    end
                    2'd1: if (!old_ldok) m_bmid = int'(wr_data);
                    2'd2: if (!old_ldok) m_bend = int'(wr_data);
                    default: ;
                endcase
            end
            if (xfer) m_ldok = 0;
            else if (wr_en && wr_addr == 2'd3 && wr_data[0]) m_ldok = 1;
            m_stb = xfer;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input logic [1:0] a);
        case (a)
            2'd0: return (m_bdiv << 4) | (m_imm << 2) | (m_end_en << 1) | m_mid_en;
            2'd1: return m_bmid;
            2'd2: return m_bend;
            default: return (m_dt << 1) | m_ldok;
        endcase
    endfunction

    task automatic cycle();
        @(negedge clk);
        chk(int'(cnt) == m_cnt, "R2 counter", int'(cnt), m_cnt);
        chk(reload_stb == m_stb, "R8 strobe", reload_stb, m_stb);
        chk(int'(act_mid) == m_amid, "R4 R5 R7 active mid", int'(act_mid), m_amid);
        chk(int'(act_end) == m_aend, "R4 R5 R7 active end", int'(act_end), m_aend);
        chk(int'(act_div) == m_adiv, "R3 active divider", int'(act_div), m_adiv);
        chk(dt_cap == m_dt, "R11 captures", dt_cap, m_dt);
        chk(int'(rd_data) == model_rd(rd_addr), "R9 R12 read data", int'(rd_data), model_rd(rd_addr));
        wr_en   = 1'b0;
        rd_addr = rd_addr + 2'd1;
        cap_in  = $urandom_range(0, 1);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        cycle();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #(20 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(act_mid == 4 && act_end == 9 && act_div == 0 && dt_cap == 0 && !reload_stb,
            "R1 reset values", int'(act_end), 9);
        chk(cnt <= 1, "R1 counter from zero", int'(cnt), 1);

        // R5 end-point reload
        wr(2'd1, 3); wr(2'd2, 7); wr(2'd0, 2);
        wr(2'd3, 0);              // R12 no effect
        run(5);
        wr(2'd3, 1);
        run(30);
        chk(act_end == 7 && act_mid == 3, "R5 end-point transfer", int'(act_end), 7);

        // R4 mid-point reload
        wr(2'd0, 1); wr(2'd1, 5); wr(2'd2, 11); wr(2'd3, 1);
        run(30);
        chk(act_mid == 5 && act_end == 11, "R4 mid-point transfer", int'(act_mid), 5);

        // R6 no source: stays armed; R10 locked writes
        wr(2'd0, 0); wr(2'd1, 2); wr(2'd3, 1);
        run(40);
        chk(act_mid == 5, "R6 no transfer without source", int'(act_mid), 5);
        wr(2'd1, 9); wr(2'd2, 20); wr(2'd0, 16'h0070);
        run(3);
        rd_addr = 2'd1; cycle();
        // R7 immediate load
        wr(2'd0, 4);
        run(4);
        chk(act_mid == 2 && act_end == 11 && act_div == 0, "R7 R10 immediate load of pre-lock values",
            int'(act_mid), 2);

        // R3 divider 2 with end-point reload
        wr(2'd0, 16'h0022); wr(2'd2, 12); wr(2'd3, 1);
        run(120);
        chk(act_div == 2, "R3 divider loaded", int'(act_div), 2);
        begin
            int gap;
            logic [W-1:0] c0;
            c0 = cnt;
            while (cnt == c0) cycle();
            c0 = cnt; gap = 0;
            while (cnt == c0) begin cycle(); gap++; end
            chk(gap == 4, "R3 tick spacing", gap, 4);
        end

        // both reload points, divider back to 0
        wr(2'd0, 16'h0003); wr(2'd1, 6); wr(2'd2, 10); wr(2'd3, 1);
        run(300);
        wr(2'd3, 1); wr(2'd1, 1);
        run(200);
        // shrink period below current counter at mid-point reload
        wr(2'd0, 1); wr(2'd1, 8); wr(2'd2, 3); wr(2'd3, 1);
        run(100);
        chk(act_end == 3, "R2 R4 shortened period", int'(act_end), 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule